// File: doc/BRIEF.md
# Variable-Width Down-Counting Timer Register

This block is a software-visible down-counter. It is built with a physical width anywhere from 32 to 64 bits. A mode bit chooses between a narrow legacy view, where only the low 32 bits take part, and a wide view that uses every physical bit. Software loads the counter through a 64-bit write port and observes it through a 64-bit read port. Every pulse on the timebase tick input subtracts one.

The read port always presents a 64-bit value that is sign-extended from the top bit of the active width. Writes drop any bits above that width without reporting it. A program can therefore find the physical width by writing progressively narrower all-ones patterns and checking whether bit 63 reads back set. A sticky pending output goes high when the active top bit turns from 0 to 1. It drops only when the counter is loaded with a value whose active top bit is 0.

Top module: `vardec_timer`

## Requirements
- R1: While reset is held, and on its release, the read port shows 0, the pending output is low and the legacy mode is selected.
- R2: In wide mode, a write keeps bits [PHYS_W-1:0] of the write data and discards every higher bit.
- R3: In wide mode, read bits [63:PHYS_W] all equal counter bit PHYS_W-1.
- R4: In legacy mode, a write keeps only bits [31:0] and clears the physical bits above them. A read returns counter bits [31:0] sign-extended from bit 31.
- R5: Each cycle with tick high and no write lowers the counter by exactly one. This includes the cycle right after a write.
- R6: When a write and a tick arrive in the same cycle, the written value is stored and no decrement is applied.
- R7: Decrementing from zero wraps to all ones within the active width, so the read port shows 64'hFFFF_FFFF_FFFF_FFFF.
- R8: Changing the mode bit (mode_wr_en with mode_wr_val, 1 = wide) leaves the counter bits untouched. The read extension and the pending detection switch to the new width on the very next cycle.
- R9: The pending output rises at the clock edge where the active top bit goes from 0 to 1, whether a tick, a write or a mode change causes it. It then stays high while no write occurs.
- R10: A write whose stored value has active top bit 0 clears the pending output at that edge. A write with top bit 1 leaves it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| tick | input | 1 | Timebase pulse, one decrement per high cycle |
| wr_en | input | 1 | Counter write strobe |
| wr_data | input | 64 | Counter write value |
| mode_wr_en | input | 1 | Mode bit write strobe |
| mode_wr_val | input | 1 | New mode bit: 1 = wide, 0 = legacy |
| rd_data | output | 64 | Counter value, sign-extended from the active width |
| irq_pending | output | 1 | Sticky exception-pending flag |

## Verification
On every cycle, the checker confirms four things. The read port's upper bits are a clean sign extension in both modes. An idle or ticking cycle either holds or decrements the low bits by one. Wide-mode writes, including those that collide with a tick, land truncated. The pending flag rises only with a negative reading, holds until a write and clears on a non-negative load. Some behaviour needs stimulus and is shown only by the directed scenarios: the legacy clearing of upper physical bits, wrap-around from zero, and a value surviving a mode round trip. So is the pending flag rising because a mode switch exposes bit 31.

// File: rtl/vardec_pkg.sv
// Shared constants and helpers for the variable-width timer register.
// Assumes all counter values are passed zero-extended to 64 bits.
package vardec_pkg;

    localparam int unsigned LEGACY_W = 32;

    // Top bit of the active width: bit w-1 in wide mode, bit 31 otherwise.
    function automatic logic active_top(input logic [63:0] v, input logic wide,
                                        input int unsigned w);
        return wide ? v[w-1] : v[LEGACY_W-1];
    endfunction

    // Sign-extend the low w bits of v to 64 bits (w in 1..64).
    function automatic logic [63:0] sext(input logic [63:0] v, input int unsigned w);
        logic signed [63:0] t;
        t = $signed(v << (64 - w));
        return 64'(t >>> (64 - w));
    endfunction

endpackage

// File: rtl/vardec_core.sv
// Counter and mode registers. Computes the next state so that the pending
// logic can see the same-edge transition. Assumes 32 <= W <= 64.
// A write wins over a tick. A write is truncated using the mode in force
// before the edge.
module vardec_core #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wr_en,
    input  logic [63:0]  wr_data,
    input  logic         mode_wr_en,
    input  logic         mode_wr_val,
    output logic [W-1:0] cnt_q,
    output logic         mode_q,
    output logic [W-1:0] cnt_d,
    output logic         mode_d
);
    import vardec_pkg::*;

    localparam logic [63:0] LEGACY_MASK = 64'h0000_0000_FFFF_FFFF;
    localparam logic [63:0] WIDE_MASK   = ~64'd0;

    logic [63:0] wr_masked;

    // Next-state selection: write, else decrement on tick, else hold.
    always_comb begin
        wr_masked = wr_data & (mode_q ? WIDE_MASK : LEGACY_MASK);
        mode_d    = mode_wr_en ? mode_wr_val : mode_q;
        if (wr_en)
            cnt_d = W'(wr_masked);
        else if (tick)
            cnt_d = cnt_q - W'(1);
        else
            cnt_d = cnt_q;
    end

    // State registers with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            mode_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            mode_q <= mode_d;
        end
    end

endmodule

// File: rtl/vardec_view.sv
// Read-side formatting. Sign-extends the counter from the active width.
// Purely combinational. Assumes 32 <= W <= 64.
module vardec_view #(
    parameter int unsigned W = 48
) (
    input  logic [W-1:0] cnt,
    input  logic         wide,
    output logic [63:0]  rd_data
);
    import vardec_pkg::*;

    // Choose the extension width by mode.
    always_comb begin
        rd_data = wide ? sext(64'(cnt), W) : sext(64'(cnt), LEGACY_W);
    end

endmodule

// File: rtl/vardec_pending.sv
// Sticky pending flag. It sets when the active top bit goes 0 -> 1 between
// the current and the next state. It clears when a write stores a value
// whose active top bit is 0. Assumes next-state inputs from vardec_core.
module vardec_pending #(
    parameter int unsigned W = 48
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic [W-1:0] cnt_q,
    input  logic         mode_q,
    input  logic [W-1:0] cnt_d,
    input  logic         mode_d,
    output logic         pending
);
    import vardec_pkg::*;

    logic top_now, top_next, pend_d;

    // Edge detect on the active top bit, with clear on a non-negative write.
    always_comb begin
        top_now  = active_top(64'(cnt_q), mode_q, W);
        top_next = active_top(64'(cnt_d), mode_d, W);
        if (wr_en && !top_next)
            pend_d = 1'b0;
        else
            pend_d = pending | (top_next & ~top_now);
    end

    // Flag register with synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) pending <= 1'b0;
        else        pending <= pend_d;
    end

endmodule

// File: rtl/vardec_timer.sv
// Top of the variable-width decrementer. PHYS_W sets the physical width
// (32..64). mode bit 1 = wide view, 0 = legacy 32-bit view.
module vardec_timer #(
    parameter int unsigned PHYS_W = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        tick,
    input  logic        wr_en,
    input  logic [63:0] wr_data,
    input  logic        mode_wr_en,
    input  logic        mode_wr_val,
    output logic [63:0] rd_data,
    output logic        irq_pending
);
    logic [PHYS_W-1:0] cnt_q, cnt_d;
    logic              mode_q, mode_d;

    vardec_core #(.W(PHYS_W)) core_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
        .cnt_q(cnt_q), .mode_q(mode_q), .cnt_d(cnt_d), .mode_d(mode_d)
    );

    vardec_view #(.W(PHYS_W)) view_i (
        .cnt(cnt_q), .wide(mode_q), .rd_data(rd_data)
    );

    vardec_pending #(.W(PHYS_W)) pend_i (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .cnt_q(cnt_q), .mode_q(mode_q), .cnt_d(cnt_d), .mode_d(mode_d),
        .pending(irq_pending)
    );

endmodule

// File: rtl/vardec_timer_chk.sv
// Cycle-level properties of the timer register, bound to vardec_timer.
module vardec_timer_chk #(
    parameter int unsigned W = 48
) (
    input logic         clk,
    input logic         rst_n,
    input logic         tick,
    input logic         wr_en,
    input logic [W-1:0] wr_lo,
    input logic         mode_wr_en,
    input logic         wide,
    input logic [63:0]  rd_data,
    input logic         irq
);
    // R2
    wide_write_trunc_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !tick && wide && !mode_wr_en) |=> rd_data[W-1:0] == $past(wr_lo));
    // R3
    wide_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wide |-> ((&rd_data[63:W-1]) || !(|rd_data[63:W-1])));
    // R4
    legacy_sign_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !wide |-> ((&rd_data[63:31]) || !(|rd_data[63:31])));
    // R5
    tick_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !wr_en && !mode_wr_en) |=> rd_data[31:0] == $past(rd_data[31:0]) - 32'd1);
    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !wr_en && !mode_wr_en) |=> $stable(rd_data));
    // R6
    write_beats_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tick && wide && !mode_wr_en) |=> rd_data[W-1:0] == $past(wr_lo));
    // R9
    irq_rise_neg_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> rd_data[63]);
    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !wr_en) |=> irq);
    // R10
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wide && !mode_wr_en && !wr_lo[W-1]) |=> !irq);
endmodule

bind vardec_timer vardec_timer_chk #(.W(PHYS_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en),
    .wr_lo(wr_data[PHYS_W-1:0]), .mode_wr_en(mode_wr_en), .wide(mode_q),
    .rd_data(rd_data), .irq(irq_pending)
);

// File: tb/vardec_timer_tb_top.sv
// Directed bench for vardec_timer with PHYS_W = 48.
module vardec_timer_tb_top;
    localparam int unsigned PW = 48;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        tick = 1'b0;
    logic        wr_en = 1'b0;
    logic [63:0] wr_data = '0;
    logic        mode_wr_en = 1'b0;
    logic        mode_wr_val = 1'b0;
    logic [63:0] rd_data;
    logic        irq_pending;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    vardec_timer #(.PHYS_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .tick(tick), .wr_en(wr_en), .wr_data(wr_data),
        .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
        .rd_data(rd_data), .irq_pending(irq_pending)
    );

    // One clock with the given strobes. Inputs clear 5 ns after the edge.
    task automatic cyc(input bit we, input logic [63:0] d, input bit tk,
                       input bit mwe, input bit mwv);
        wr_en = we; wr_data = d; tick = tk; mode_wr_en = mwe; mode_wr_val = mwv;
        @(posedge clk); #5;
        wr_en = 0; tick = 0; mode_wr_en = 0;
    endtask

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic t_reset;
        chk("R1 read at reset", rd_data, 64'd0);
        chk("R1 pending at reset", 64'(irq_pending), 64'd0);
        // A write with bit 32 set must be truncated to 32 bits if legacy is selected.
        rst_n = 1'b1;
        cyc(1, 64'h0000_0001_0000_0007, 0, 0, 0);
        chk("R1 legacy after reset", rd_data, 64'h7);
    endtask

    task automatic t_legacy;
        cyc(1, 64'hDEAD_BEEF_8000_0005, 0, 0, 0);
        chk("R4 legacy write/sext", rd_data, 64'hFFFF_FFFF_8000_0005);
        chk("R9 pending on negative load", 64'(irq_pending), 64'd1);
        cyc(1, 64'h10, 0, 0, 0);
        chk("R10 clear on positive load", 64'(irq_pending), 64'd0);
        cyc(0, 0, 1, 0, 0);
        chk("R5 tick after write", rd_data, 64'hF);
        cyc(0, 0, 1, 0, 0);
        chk("R5 second tick", rd_data, 64'hE);
        cyc(1, 64'h5, 1, 0, 0);
        chk("R6 write beats tick", rd_data, 64'h5);
    endtask

    task automatic t_wrap;
        cyc(1, 64'h1, 0, 0, 0);
        cyc(0, 0, 1, 0, 0);
        chk("R5 reach zero", rd_data, 64'h0);
        chk("R9 no pending at zero", 64'(irq_pending), 64'd0);
        cyc(0, 0, 1, 0, 0);
        chk("R7 legacy wrap", rd_data, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R9 pending on wrap", 64'(irq_pending), 64'd1);
        cyc(0, 0, 1, 0, 0);
        chk("R9 pending sticky", 64'(irq_pending), 64'd1);
        cyc(1, 64'h8000_0000, 0, 0, 0);
        chk("R10 negative write keeps pending", 64'(irq_pending), 64'd1);
        cyc(1, 64'h0, 0, 0, 0);
        chk("R10 zero write clears", 64'(irq_pending), 64'd0);
    endtask

    task automatic t_wide;
        cyc(0, 0, 0, 1, 1);
        chk("R8 mode switch keeps zero", rd_data, 64'h0);
        cyc(1, 64'hAAAA_5555_1234_5678, 0, 0, 0);
        chk("R2 wide truncation", rd_data, 64'h0000_5555_1234_5678);
        chk("R9 no pending positive", 64'(irq_pending), 64'd0);
        cyc(1, 64'h0000_8000_0000_0001, 0, 0, 0);
        chk("R3 wide sign extension", rd_data, 64'hFFFF_8000_0000_0001);
        chk("R9 pending wide negative", 64'(irq_pending), 64'd1);
        cyc(1, 64'h1234_0000_0000_0003, 0, 0, 0);
        chk("R2 upper bits dropped", rd_data, 64'h3);
        chk("R10 wide clear", 64'(irq_pending), 64'd0);
        for (int i = 0; i < 3; i++) cyc(0, 0, 1, 0, 0);
        chk("R5 wide countdown", rd_data, 64'h0);
        cyc(0, 0, 1, 0, 0);
        chk("R7 wide wrap", rd_data, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R9 pending wide wrap", 64'(irq_pending), 64'd1);
    endtask

    task automatic t_mode;
        cyc(1, 64'h0000_0001_0000_0000, 0, 0, 0);
        chk("R2 bit32 kept wide", rd_data, 64'h0000_0001_0000_0000);
        cyc(0, 0, 0, 1, 0);
        chk("R8 legacy view after switch", rd_data, 64'h0);
        cyc(0, 0, 1, 0, 0);
        chk("R7 legacy wrap over wide bits", rd_data, 64'hFFFF_FFFF_FFFF_FFFF);
        chk("R9 pending legacy wrap", 64'(irq_pending), 64'd1);
        cyc(0, 0, 0, 1, 1);
        chk("R8 value kept across switch", rd_data, 64'h0000_0000_FFFF_FFFF);
        cyc(1, 64'h8000_0000, 0, 0, 0);
        chk("R10 wide positive clears", 64'(irq_pending), 64'd0);
        cyc(0, 0, 0, 1, 0);
        chk("R8 legacy sign bit exposed", rd_data, 64'hFFFF_FFFF_8000_0000);
        chk("R9 pending from mode switch", 64'(irq_pending), 64'd1);
    endtask

    task automatic finish_run;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #5;
        t_reset();
        t_legacy();
        t_wrap();
        t_wide();
        t_mode();
        done = 1'b1;
        finish_run();
    end

    initial begin
        #(20 * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired");
            finish_run();
        end
    end

endmodule